// File: doc/BRIEF.md
# Error Exception Entry Sequencer

This block steers a processor into its handler when an address error or a bus error has been reported. Each error report is caught in a pending latch. A bus error report is caught only while the bus-error notification enable is high. The sequencer then waits for an instruction boundary at which the bus is also quiet.

When that boundary arrives, the sequencer takes a snapshot of the status word, the next-instruction address and the stack pointer. It then runs a fixed series of steps on one memory port:
1. Read the handler address from the vector table.
2. Push the status word onto a downward-growing stack.
3. Push the return address onto the same stack.
4. Issue a jump with no delay slot, which redirects fetch to the handler and hands back the new stack pointer.

The core feeds the sequencer two levels, "instruction completed" and "bus idle". It consumes the one-cycle completion pulse together with the new program counter and stack pointer.

Top module: `exc_entry_seq`

## Requirements
- R1: A one-cycle `addrErrReq` always becomes pending. A one-cycle `busErrReq` becomes pending only if `busErrNotifyEn` is high in that same cycle. A masked bus error is dropped: raising the enable later does not revive it.
- R2: A sequence starts only from idle, with a request pending, in a cycle where `instDone` and `busIdle` are both high. A request can start a sequence one cycle after it is presented at the earliest. `busy` is high from the cycle after the start through the completion cycle.
- R3: The first transaction is a read (`memWe`=0) at `vbr + 4*N`, where N=9 for an address error and N=16 for a bus error. The word returned on the acknowledged cycle is the handler address.
- R4: The second transaction is a write of the status word sampled at the start cycle, to address `sp - 4`, where sp is the stack pointer sampled at the start cycle.
- R5: The third transaction is a write of the next-instruction address sampled at the start cycle, to address `sp - 8`.
- R6: While `memReq` is high and `memAck` is low, the next cycle keeps `memReq` high with the same `memAddr`, `memWe` and `memWdata`.
- R7: `entryDone` is high for exactly one cycle, the cycle after the return-address write is acknowledged, with `memReq` low. In that cycle `pcOut` equals the handler word and `spOut` equals `sp - 8`.
- R8: If both kinds are pending when a sequence starts, the address error is serviced first, and the bus error is serviced by the following sequence.
- R9: A request that arrives during a sequence, including one of the kind just consumed at the start cycle, stays pending and does not disturb the running sequence. It is serviced after the return to idle.
- R10: While reset is asserted, `memReq`, `entryDone` and `busy` are low and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrErrReq | input | 1 | Address error report, one cycle per event |
| busErrReq | input | 1 | Bus error report (invalid address or timeout), one cycle per event |
| busErrNotifyEn | input | 1 | Enables capture of bus error reports |
| instDone | input | 1 | Current instruction has completed |
| busIdle | input | 1 | No bus cycle is in progress |
| vbr | input | 32 | Vector table base address |
| srIn | input | 32 | Current status word |
| nextPcIn | input | 32 | Address of the next instruction to run |
| spIn | input | 32 | Current stack pointer |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Transaction address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Transaction accepted / data valid |
| pcOut | output | 32 | Handler address, valid with entryDone |
| spOut | output | 32 | Stack pointer after the pushes, valid with entryDone |
| entryDone | output | 1 | One-cycle completion pulse (jump issued) |
| busy | output | 1 | Sequence in progress |

## Verification
Two things can land on the same clock edge. The first is the start of a sequence, which consumes a pending kind. The second is a fresh report of that same kind, which must set the latch again. The same applies to two kinds pending together, where priority decides which is consumed. The bench fires both reports in one cycle, and it also fires reports at random against random boundary and acknowledge patterns, so new reports land on start cycles. A behavioural reference model, fed the same inputs, is compared with every output on every clock; the number and order of completions show whether a report was lost or serviced twice.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    MEM_NONE,
    MEM_VEC,
    MEM_SR,
    MEM_PC
  } memSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VEC,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_JUMP
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;      // snapshot sr/pc/sp and form vector address
    logic    useBusVec;    // vector number select at capture
    logic    loadHandler;  // take read data as handler address
    logic    stepSp;       // pre-decrement completed
    memSel_e memSel;       // which address/data drive the port
  } dpStrobe_t;

endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      addrErrReq,
  input  logic      busErrReq,
  input  logic      busErrNotifyEn,
  input  logic      instDone,
  input  logic      busIdle,
  input  logic      memAck,
  output dpStrobe_t strobe,
  output logic      memReq,
  output logic      memWe,
  output logic      entryDone,
  output logic      busy
);

  // index 0 = address error (highest priority), index 1 = bus error
  logic [NUM_SRC-1:0] reqVec;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] grantVec;
  logic               start;
  seqState_e          state, stateNext;

  assign reqVec = {busErrReq & busErrNotifyEn, addrErrReq};

  // fixed priority: lowest index wins
  always_comb begin
    grantVec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendVec[i] && (grantVec == '0)) grantVec[i] = 1'b1;
    end
  end

  assign start = (state == ST_IDLE) && (|pendVec) && instDone && busIdle;

  // one pending latch per source; a new request wins over the clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendVec[g] <= 1'b0;
      else       pendVec[g] <= (pendVec[g] & ~(start & grantVec[g])) | reqVec[g];
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (start)  stateNext = ST_VEC;
      ST_VEC:     if (memAck) stateNext = ST_PUSH_SR;
      ST_PUSH_SR: if (memAck) stateNext = ST_PUSH_PC;
      ST_PUSH_PC: if (memAck) stateNext = ST_JUMP;
      ST_JUMP:                stateNext = ST_IDLE;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe             = '0;
    strobe.capture     = start;
    strobe.useBusVec   = ~grantVec[0];
    strobe.loadHandler = (state == ST_VEC) && memAck;
    strobe.stepSp      = ((state == ST_PUSH_SR) || (state == ST_PUSH_PC)) && memAck;
    unique case (state)
      ST_VEC:     strobe.memSel = MEM_VEC;
      ST_PUSH_SR: strobe.memSel = MEM_SR;
      ST_PUSH_PC: strobe.memSel = MEM_PC;
      default:    strobe.memSel = MEM_NONE;
    endcase
  end

  assign memReq    = (state == ST_VEC) || (state == ST_PUSH_SR) || (state == ST_PUSH_PC);
  assign memWe     = (state == ST_PUSH_SR) || (state == ST_PUSH_PC);
  assign entryDone = (state == ST_JUMP);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int ADDR_VEC_NUM = 9,
  parameter int BUS_VEC_NUM  = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic [XLEN-1:0] vbr,
  input  logic [XLEN-1:0] srIn,
  input  logic [XLEN-1:0] nextPcIn,
  input  logic [XLEN-1:0] spIn,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] spOut
);

  localparam int              WORD_BYTES = XLEN / 8;
  localparam logic [XLEN-1:0] STEP       = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] ADDR_OFF   = XLEN'(ADDR_VEC_NUM * WORD_BYTES);
  localparam logic [XLEN-1:0] BUS_OFF    = XLEN'(BUS_VEC_NUM * WORD_BYTES);

  logic [XLEN-1:0] vecAddr;
  logic [XLEN-1:0] srSave;
  logic [XLEN-1:0] pcSave;
  logic [XLEN-1:0] spWork;
  logic [XLEN-1:0] handler;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecAddr <= '0;
      srSave  <= '0;
      pcSave  <= '0;
      spWork  <= '0;
      handler <= '0;
    end else begin
      if (strobe.capture) begin
        vecAddr <= vbr + (strobe.useBusVec ? BUS_OFF : ADDR_OFF);
        srSave  <= srIn;
        pcSave  <= nextPcIn;
        spWork  <= spIn;
      end
      if (strobe.loadHandler) handler <= memRdata;
      if (strobe.stepSp)      spWork  <= spWork - STEP;
    end
  end

  always_comb begin
    unique case (strobe.memSel)
      MEM_VEC:        memAddr = vecAddr;
      MEM_SR, MEM_PC: memAddr = spWork - STEP;
      default:        memAddr = '0;
    endcase
    unique case (strobe.memSel)
      MEM_SR:  memWdata = srSave;
      MEM_PC:  memWdata = pcSave;
      default: memWdata = '0;
    endcase
  end

  assign pcOut = handler;
  assign spOut = spWork;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int ADDR_VEC_NUM = 9,
  parameter int BUS_VEC_NUM  = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            addrErrReq,
  input  logic            busErrReq,
  input  logic            busErrNotifyEn,
  input  logic            instDone,
  input  logic            busIdle,
  input  logic [XLEN-1:0] vbr,
  input  logic [XLEN-1:0] srIn,
  input  logic [XLEN-1:0] nextPcIn,
  input  logic [XLEN-1:0] spIn,
  output logic            memReq,
  output logic            memWe,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic [XLEN-1:0] memRdata,
  input  logic            memAck,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] spOut,
  output logic            entryDone,
  output logic            busy
);

  dpStrobe_t strobe;

  exc_entry_ctrl #(.NUM_SRC(2)) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .addrErrReq    (addrErrReq),
    .busErrReq     (busErrReq),
    .busErrNotifyEn(busErrNotifyEn),
    .instDone      (instDone),
    .busIdle       (busIdle),
    .memAck        (memAck),
    .strobe        (strobe),
    .memReq        (memReq),
    .memWe         (memWe),
    .entryDone     (entryDone),
    .busy          (busy)
  );

  exc_entry_dp #(
    .XLEN        (XLEN),
    .ADDR_VEC_NUM(ADDR_VEC_NUM),
    .BUS_VEC_NUM (BUS_VEC_NUM)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .vbr     (vbr),
    .srIn    (srIn),
    .nextPcIn(nextPcIn),
    .spIn    (spIn),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .pcOut   (pcOut),
    .spOut   (spOut)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            memReq,
  input logic            memWe,
  input logic            memAck,
  input logic [XLEN-1:0] memAddr,
  input logic [XLEN-1:0] memWdata,
  input logic            entryDone,
  input logic            busy,
  input logic            instDone,
  input logic            busIdle
);

  logic [1:0] wrCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             wrCount <= '0;
    else if (entryDone)                    wrCount <= '0;
    else if (memReq && memWe && memAck)    wrCount <= wrCount + 2'd1;
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |=> !entryDone);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryDone |-> (!memReq && wrCount == 2'd2));

  // R7
  done_after_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck && wrCount == 2'd1) |=> entryDone);

  // R4
  sr_after_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck) |=> (memReq && memWe && wrCount == 2'd0));

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(instDone && busIdle));

endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAck   (memAck),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .entryDone(entryDone),
  .busy     (busy),
  .instDone (instDone),
  .busIdle  (busIdle)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;

  localparam logic [31:0] RKEY = 32'hC0DE_0000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        addrErrReq, busErrReq, busErrNotifyEn, instDone, busIdle;
  logic [31:0] vbr, srIn, nextPcIn, spIn;
  logic        memReq, memWe, memAck, entryDone, busy;
  logic [31:0] memAddr, memWdata, memRdata, pcOut, spOut;

  always #10 clk = ~clk;  // 50 MHz

  assign memRdata = memAddr ^ RKEY;

  exc_entry_seq dut_i (
    .clk(clk), .rstN(rstN), .addrErrReq(addrErrReq), .busErrReq(busErrReq),
    .busErrNotifyEn(busErrNotifyEn), .instDone(instDone), .busIdle(busIdle),
    .vbr(vbr), .srIn(srIn), .nextPcIn(nextPcIn), .spIn(spIn),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .pcOut(pcOut), .spOut(spOut),
    .entryDone(entryDone), .busy(busy)
  );

  int checkCount = 0;
  int failCount  = 0;
  int doneSeen   = 0;
  logic [31:0] donePcs[$];
  bit compareOn = 1'b0;
  bit randAck   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int          mState;          // 0 idle, 1 vector read, 2 sr push, 3 pc push, 4 done
  bit          mPendA, mPendB;
  logic [31:0] mVec, mSr, mPc, mSp, mHandler;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mPendA = 0; mPendB = 0;
      mVec = 0; mSr = 0; mPc = 0; mSp = 0; mHandler = 0;
    end else begin
      case (mState)
        0: if ((mPendA || mPendB) && instDone && busIdle) begin
             if (mPendA) begin mPendA = 0; mVec = vbr + 32'd36; end
             else        begin mPendB = 0; mVec = vbr + 32'd64; end
             mSr = srIn; mPc = nextPcIn; mSp = spIn; mState = 1;
           end
        1: if (memAck) begin mHandler = mVec ^ RKEY; mState = 2; end
        2: if (memAck) begin mSp = mSp - 4; mState = 3; end
        3: if (memAck) begin mSp = mSp - 4; mState = 4; end
        default: mState = 0;
      endcase
      if (addrErrReq) mPendA = 1;
      if (busErrReq && busErrNotifyEn) mPendB = 1;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && compareOn) begin
      chk(busy == (mState != 0), "R2 busy", 32'(busy), 32'(mState != 0));
      chk(memReq == (mState >= 1 && mState <= 3), "R9 memReq", 32'(memReq), 32'(mState >= 1 && mState <= 3));
      chk(entryDone == (mState == 4), "R7 entryDone", 32'(entryDone), 32'(mState == 4));
      if (mState == 1) begin
        chk(memWe == 1'b0, "R3 read", 32'(memWe), 32'd0);
        chk(memAddr == mVec, "R3 vector address", memAddr, mVec);
      end
      if (mState == 2) begin
        chk(memWe == 1'b1, "R4 write", 32'(memWe), 32'd1);
        chk(memAddr == mSp - 4, "R4 sr address", memAddr, mSp - 4);
        chk(memWdata == mSr, "R4 sr data", memWdata, mSr);
      end
      if (mState == 3) begin
        chk(memWe == 1'b1, "R5 write", 32'(memWe), 32'd1);
        chk(memAddr == mSp - 4, "R5 pc address", memAddr, mSp - 4);
        chk(memWdata == mPc, "R5 pc data", memWdata, mPc);
      end
      if (mState == 4) begin
        chk(pcOut == mHandler, "R7 pcOut", pcOut, mHandler);
        chk(spOut == mSp, "R7 spOut", spOut, mSp);
      end
      if (entryDone) begin
        doneSeen++;
        donePcs.push_back(pcOut);
      end
    end
  end

  // free-running data inputs and memory acknowledge
  always @(negedge clk) begin
    srIn     <= $urandom;
    nextPcIn <= $urandom & 32'hFFFF_FFFE;
    spIn     <= $urandom & 32'hFFFF_FFFC;
    memAck   <= randAck ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit a, input bit b);
    @(negedge clk);
    addrErrReq = a; busErrReq = b;
    @(negedge clk);
    addrErrReq = 0; busErrReq = 0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int base;
    rstN = 0; addrErrReq = 0; busErrReq = 0; busErrNotifyEn = 0;
    instDone = 0; busIdle = 0; vbr = 32'h0000_1000;
    ticks(3);
    // R10 reset state
    chk(memReq == 0, "R10 memReq in reset", 32'(memReq), 0);
    chk(entryDone == 0, "R10 entryDone in reset", 32'(entryDone), 0);
    chk(busy == 0, "R10 busy in reset", 32'(busy), 0);
    rstN = 1; compareOn = 1;
    ticks(2);

    // R3 address error entry
    instDone = 1; busIdle = 1;
    pulse(1, 0);
    ticks(10);
    chk(doneSeen == 1, "R3 one entry", 32'(doneSeen), 1);
    chk(donePcs[0] == ((32'h1000 + 32'd36) ^ RKEY), "R3 address error handler", donePcs[0], (32'h1000 + 32'd36) ^ RKEY);

    // R2 bus not idle delays entry
    busErrNotifyEn = 1; busIdle = 0;
    pulse(0, 1);
    ticks(8);
    chk(doneSeen == 1, "R2 no entry while bus busy", 32'(doneSeen), 1);
    chk(busy == 0, "R2 idle while waiting", 32'(busy), 0);
    busIdle = 1; instDone = 0;
    ticks(6);
    chk(doneSeen == 1, "R2 no entry before instruction done", 32'(doneSeen), 1);
    instDone = 1;
    ticks(10);
    chk(doneSeen == 2, "R2 entry after boundary", 32'(doneSeen), 2);
    chk(donePcs[1] == ((32'h1000 + 32'd64) ^ RKEY), "R3 bus error handler", donePcs[1], (32'h1000 + 32'd64) ^ RKEY);

    // R1 masked bus error is dropped
    busErrNotifyEn = 0;
    pulse(0, 1);
    ticks(10);
    chk(doneSeen == 2, "R1 masked bus error", 32'(doneSeen), 2);
    busErrNotifyEn = 1;
    ticks(10);
    chk(doneSeen == 2, "R1 masked error not revived", 32'(doneSeen), 2);

    // R8 both kinds at once
    vbr = 32'h0002_0000;
    pulse(1, 1);
    ticks(20);
    chk(doneSeen == 4, "R8 two entries", 32'(doneSeen), 4);
    chk(donePcs[2] == ((32'h2_0000 + 32'd36) ^ RKEY), "R8 address error first", donePcs[2], (32'h2_0000 + 32'd36) ^ RKEY);
    chk(donePcs[3] == ((32'h2_0000 + 32'd64) ^ RKEY), "R8 bus error second", donePcs[3], (32'h2_0000 + 32'd64) ^ RKEY);

    // R9 request during a running sequence, with stalled acknowledges
    randAck = 1;
    pulse(1, 0);
    ticks(2);
    pulse(0, 1);
    ticks(60);
    chk(doneSeen == 6, "R9 held request serviced", 32'(doneSeen), 6);
    chk(donePcs[5] == ((32'h2_0000 + 32'd64) ^ RKEY), "R9 held bus error", donePcs[5], (32'h2_0000 + 32'd64) ^ RKEY);

    // random phase: reports collide with start cycles (R9, R8, R6)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      addrErrReq     = (($urandom % 10) == 0);
      busErrReq      = (($urandom % 8) == 0);
      busErrNotifyEn = (($urandom % 4) != 0);
      instDone       = (($urandom % 3) != 0);
      busIdle        = (($urandom % 4) != 0);
      if ((i % 500) == 0) vbr = $urandom & 32'hFFFF_FF00;
    end
    @(negedge clk);
    addrErrReq = 0; busErrReq = 0; instDone = 1; busIdle = 1;
    ticks(100);
    base = doneSeen;
    chk(busy == 0, "R9 drained", 32'(busy), 0);
    ticks(5);
    chk(doneSeen == base, "R9 nothing left pending", 32'(doneSeen), 32'(base));
    finishRun();
  end

endmodule